// File: doc/BRIEF.md
# SDRAM Burst Frame-Store Sequencer

This block drives the command, address and data pins of an SDRAM that holds a video frame. A client asks for a 32-word transfer by giving a direction, a row and a starting column. The block opens the row once. It then issues four column strobes eight clocks apart, so that four 8-beat bursts run back to back with no gap in the data. Only the last strobe closes the row, by raising address bit 10 to request auto-precharge.

After reset the block keeps chip select high for a settling period. It then writes the SDRAM mode register once, waits a short interval, and starts taking requests. Write words come from the client, one per clock, under a take strobe. Read words go back to the client with a valid flag, in the order the columns were read. A one-clock done pulse marks the end of each transfer.

Top module: `sdram_burst_seq`

## Requirements
- R1: Chip select (active low) stays high from reset release until the mode-register write, and stays low from that write onward.
- R2: Exactly one mode-register write is issued, INIT_WAIT clocks after reset release. On that clock chip select, RAS, CAS and WE are all low and A carries 0x033: A[2:0]=3 (8-beat bursts), A[3]=0 (sequential order), A[6:4]=3 (CAS latency 3), all other bits 0.
- R3: In reset and between transfers, RAS, CAS and WE are high and the data output enable is low. The enable is high on exactly the 32 beat clocks of a write.
- R4: An activate (chip select and RAS low, CAS and WE high, row on A) comes one clock after a request is accepted. The first column strobe follows exactly three clocks after the activate.
- R5: Each transfer has four strobes (RAS high, CAS low) eight clocks apart, with WE low for a write and high for a read. The strobe column sits on A[7:0], and the beat column rises by one per clock and wraps modulo 256.
- R6: A10 is high on the fourth strobe of a transfer and low on the first three.
- R7: During a write, wr_ready is high on each beat. The word on wr_data goes out on sd_dq_out in that same clock, and words are used in the order given. Read words come back on rd_data in column order.
- R8: A read word is returned on rd_data, with rd_valid high, four clocks after its beat clock: CAS latency 3 plus one capture register.
- R9: done pulses for one clock. For a write it comes one clock after the last beat; for a read, one clock after the last rd_valid.
- R10: req_ready is low from acceptance until the transfer ends. It returns TRP+1 clocks after the last write beat, or CAS_LAT+2 clocks after the last read beat. A request held while req_ready is low is accepted when it returns.
- R11: req_ready first rises MRD_WAIT+1 clocks after the mode-register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Transfer request pending |
| req_write | input | 1 | 1 = write transfer, 0 = read |
| req_row | input | 12 | Row to open |
| req_col | input | 8 | First column of the 32 words |
| req_ready | output | 1 | Request can be accepted this clock |
| wr_data | input | 16 | Current write word from the client |
| wr_ready | output | 1 | wr_data is taken this clock |
| rd_valid | output | 1 | rd_data holds a read word |
| rd_data | output | 16 | Captured read word |
| done | output | 1 | One-clock end-of-transfer pulse |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 12 | Address / mode word |
| sd_dq_oe | output | 1 | Data pin output enable |
| sd_dq_out | output | 16 | Data driven to the SDRAM |
| sd_dq_in | input | 16 | Data returned by the SDRAM |

## Verification
Results fall due at fixed offsets from their cause. The activate comes one clock after acceptance and the first strobe three clocks after it. A write word appears on the bus in its own beat clock, a read word on rd_valid four clocks after its beat, and done one clock after the final write beat or the final read word. req_ready returns TRP+1 clocks after a write's last beat and CAS_LAT+2 clocks after a read's. The bench counts clocks at falling edges and records the clock of every beat. It compares each event against its recorded clock plus the stated offset, never against a time window. Its SDRAM model returns read data exactly three clocks after each read beat.

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq #(
  parameter int ADDR_W    = 12,
  parameter int COL_W     = 8,
  parameter int DATA_W    = 16,
  parameter int BURST     = 8,
  parameter int NBURST    = 4,
  parameter int TRCD      = 3,
  parameter int CAS_LAT   = 3,
  parameter int TRP       = 3,
  parameter int INIT_WAIT = 8,
  parameter int MRD_WAIT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              req_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              sd_dq_oe,
  output logic [DATA_W-1:0] sd_dq_out,
  input  logic [DATA_W-1:0] sd_dq_in
);
  localparam int XFER_LEN = BURST * NBURST;
  localparam int BL_CODE  = $clog2(BURST);
  localparam int CNT_W    = $clog2(INIT_WAIT + MRD_WAIT + TRCD + XFER_LEN + TRP + CAS_LAT + 2);
  localparam logic [ADDR_W-1:0] MODE_WORD = ADDR_W'({3'(CAS_LAT), 1'b0, 3'(BL_CODE)});

  typedef enum logic [2:0] {S_INIT, S_MRS, S_MRD, S_IDLE, S_ACT, S_RCD, S_XFER, S_PRE} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic              wr_q;
  logic [ADDR_W-1:0] row_q;
  logic [COL_W-1:0]  col_q;
  logic [CAS_LAT-1:0] pb, pl;
  logic              rl_q;

  wire in_x        = (st == S_XFER);
  wire strobe      = in_x && (cnt[BL_CODE-1:0] == '0);
  wire last_beat   = in_x && (cnt == CNT_W'(XFER_LEN - 1));
  wire last_strobe = in_x && (cnt == CNT_W'(XFER_LEN - BURST));
  wire rd_beat     = in_x && !wr_q;
  wire [COL_W-1:0] col_now = col_q + COL_W'(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_INIT;
      cnt   <= '0;
      wr_q  <= 1'b0;
      row_q <= '0;
      col_q <= '0;
    end else begin
      unique case (st)
        S_INIT: if (cnt == CNT_W'(INIT_WAIT - 1)) begin st <= S_MRS; cnt <= '0; end
                else cnt <= cnt + 1'b1;
        S_MRS:  begin st <= S_MRD; cnt <= '0; end
        S_MRD:  if (cnt == CNT_W'(MRD_WAIT - 1)) begin st <= S_IDLE; cnt <= '0; end
                else cnt <= cnt + 1'b1;
        S_IDLE: if (req_valid) begin
                  st    <= S_ACT;
                  wr_q  <= req_write;
                  row_q <= req_row;
                  col_q <= req_col;
                end
        S_ACT:  begin st <= S_RCD; cnt <= '0; end
        S_RCD:  if (cnt == CNT_W'(TRCD - 2)) begin st <= S_XFER; cnt <= '0; end
                else cnt <= cnt + 1'b1;
        S_XFER: if (last_beat) begin st <= S_PRE; cnt <= '0; end
                else cnt <= cnt + 1'b1;
        S_PRE:  if (cnt >= CNT_W'(TRP - 1) && pb == '0) begin st <= S_IDLE; cnt <= '0; end
                else cnt <= cnt + 1'b1;
        default: st <= S_INIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pb       <= '0;
      pl       <= '0;
      rl_q     <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      done     <= 1'b0;
    end else begin
      pb       <= (pb << 1) | CAS_LAT'(rd_beat);
      pl       <= (pl << 1) | CAS_LAT'(rd_beat && last_beat);
      rd_valid <= pb[CAS_LAT-1];
      rl_q     <= pl[CAS_LAT-1];
      if (pb[CAS_LAT-1]) rd_data <= sd_dq_in;
      done     <= (last_beat && wr_q) || rl_q;
    end
  end

  assign req_ready = (st == S_IDLE);
  assign wr_ready  = in_x && wr_q;
  assign sd_dq_oe  = in_x && wr_q;
  assign sd_dq_out = wr_data;
  assign sd_cs_n   = (st == S_INIT);
  assign sd_ras_n  = !(st == S_MRS || st == S_ACT);
  assign sd_cas_n  = !(st == S_MRS || strobe);
  assign sd_we_n   = !(st == S_MRS || (strobe && wr_q));

  always_comb begin
    sd_addr = '0;
    unique case (st)
      S_MRS:  sd_addr = MODE_WORD;
      S_ACT:  sd_addr = row_q;
      S_XFER: begin
        sd_addr[COL_W-1:0] = col_now;
        sd_addr[10]        = last_strobe;
      end
      default: sd_addr = '0;
    endcase
  end

  AST_CS_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n) !sd_cs_n |=> !sd_cs_n); // R1
  AST_ACT_THEN_NOP: assert property (@(posedge clk) disable iff (!rst_n) (!sd_ras_n && sd_cas_n) |=> (sd_ras_n && sd_cas_n)); // R4
  AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n) (sd_ras_n && !sd_cas_n) |=> sd_cas_n); // R5
  AST_OE_NO_ROW_CMD: assert property (@(posedge clk) disable iff (!rst_n) sd_dq_oe |-> (sd_ras_n && !sd_cs_n)); // R3
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> (!sd_dq_oe && sd_cas_n && !wr_ready)); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
endmodule

// File: tb/test_sdram_burst_seq.sv
module test_sdram_burst_seq;
  localparam int CLK_PERIOD = 10;
  localparam int INIT_WAIT  = 8;
  localparam int MRD_WAIT   = 2;
  localparam int TRP        = 3;
  localparam int CAS_LAT    = 3;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [11:0] req_row = '0;
  logic [7:0]  req_col = '0;
  logic req_ready, wr_ready, rd_valid, done;
  logic [15:0] wr_data = '0, rd_data;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [11:0] sd_addr;
  logic [15:0] sd_dq_out, sd_dq_in = '0;

  sdram_burst_seq i_sdram_burst_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_row(req_row), .req_col(req_col), .req_ready(req_ready),
    .wr_data(wr_data), .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .done(done), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_dq_oe(sd_dq_oe),
    .sd_dq_out(sd_dq_out), .sd_dq_in(sd_dq_in));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0, n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int key_of(logic [11:0] r, logic [7:0] c);
    return int'({r, c});
  endfunction

  function automatic logic [15:0] pat(logic [11:0] r, logic [7:0] c);
    return {r[7:0] ^ 8'h5A, c};
  endfunction

  logic [15:0] mem[int];
  logic [15:0] shadow[int];
  logic [15:0] pend[int];
  logic [15:0] wr_src[$];
  int          exp_wr_key[$];
  logic [15:0] exp_wr_dat[$];
  logic [15:0] exp_rd[$];
  int          rdcyc[$];

  int cyc = 0, mrs_cyc = 0, acc_cyc = -10, act_cyc = 0, last_strobe_cyc = 0;
  int nstrobe = 0, blen = 0, exp_done = -1, ready_due = 0, rd_seen = 0;
  bit mrs_seen = 0, first_ready = 0, ready_arm = 0, cur_wr = 0;
  logic [11:0] cur_row = '0;
  logic [7:0]  bcol = '0;

  always @(negedge clk) begin
    bit is_mrs, is_act, is_cas;
    int k, ek, b;
    logic [15:0] ed;
    if (rst_n) begin
      cyc++;
      is_mrs = !sd_cs_n && !sd_ras_n && !sd_cas_n && !sd_we_n;
      is_act = !sd_cs_n && !sd_ras_n && sd_cas_n && sd_we_n;
      is_cas = !sd_cs_n && sd_ras_n && !sd_cas_n;
      if (!mrs_seen) begin
        if (is_mrs) begin
          mrs_seen = 1; mrs_cyc = cyc;
          chk(sd_addr == 12'h033, "R2 mode word", sd_addr, 12'h033);
          chk(cyc == INIT_WAIT, "R2 mode write clock", cyc, INIT_WAIT);
        end else if (sd_cs_n !== 1'b1) chk(0, "R1 select during init", sd_cs_n, 1);
      end else begin
        if (sd_cs_n !== 1'b0) chk(0, "R1 select after mode write", sd_cs_n, 0);
        if (is_mrs) chk(0, "R2 repeated mode write", 1, 0);
      end
      if (req_ready && !first_ready) begin
        first_ready = 1;
        chk(mrs_seen && cyc == mrs_cyc + MRD_WAIT + 1, "R11 first ready", cyc, mrs_cyc + MRD_WAIT + 1);
      end
      if (req_valid && req_ready) acc_cyc = cyc;
      if (is_act) begin
        chk(cyc == acc_cyc + 1, "R4 activate after accept", cyc, acc_cyc + 1);
        cur_row = sd_addr; act_cyc = cyc; nstrobe = 0;
      end
      if (is_cas) begin
        nstrobe++;
        if (nstrobe == 1) begin
          chk(cyc == act_cyc + 3, "R4 activate to strobe", cyc, act_cyc + 3);
          cur_wr = !sd_we_n;
        end else begin
          chk(cyc == last_strobe_cyc + 8, "R5 strobe spacing", cyc, last_strobe_cyc + 8);
          chk((!sd_we_n) == cur_wr, "R5 strobe kind", !sd_we_n, cur_wr);
        end
        chk(nstrobe <= 4, "R5 strobe count", nstrobe, 4);
        chk(sd_addr[10] == (nstrobe == 4), "R6 precharge bit", sd_addr[10], nstrobe == 4);
        bcol = sd_addr[7:0]; blen = 8; last_strobe_cyc = cyc;
      end
      if (blen > 0) begin
        k = key_of(cur_row, bcol);
        if (cur_wr) begin
          chk(sd_dq_oe, "R3 enable on write beat", sd_dq_oe, 1);
          chk(wr_ready, "R7 take strobe on beat", wr_ready, 1);
          if (exp_wr_key.size() == 0) chk(0, "R7 unexpected write beat", k, 0);
          else begin
            ek = exp_wr_key.pop_front(); ed = exp_wr_dat.pop_front();
            chk(k == ek, "R5 write column", k, ek);
            chk(sd_dq_out == ed, "R7 write word", sd_dq_out, ed);
          end
          mem[k] = sd_dq_out;
        end else begin
          chk(!sd_dq_oe, "R3 enable on read beat", sd_dq_oe, 0);
          pend[cyc + 3] = mem.exists(k) ? mem[k] : pat(cur_row, bcol);
          rdcyc.push_back(cyc);
        end
        bcol++; blen--;
        if (blen == 0 && nstrobe == 4) begin
          if (cur_wr) begin exp_done = cyc + 1; ready_due = cyc + TRP + 1; end
          else ready_due = cyc + CAS_LAT + 2;
          ready_arm = 1;
        end
      end else begin
        if (sd_dq_oe) chk(0, "R3 enable outside write", 1, 0);
        if (wr_ready) chk(0, "R7 take strobe outside write", 1, 0);
      end
      if (rd_valid) begin
        if (rdcyc.size() == 0) chk(0, "R8 unexpected read word", rd_data, 0);
        else begin
          b = rdcyc.pop_front();
          chk(cyc == b + CAS_LAT + 1, "R8 read latency", cyc, b + CAS_LAT + 1);
        end
        if (exp_rd.size() == 0) chk(0, "R7 read word not expected", rd_data, 0);
        else begin
          ed = exp_rd.pop_front();
          chk(rd_data == ed, "R7 read word", rd_data, ed);
        end
        rd_seen++;
        if (rd_seen % 32 == 0) exp_done = cyc + 1;
      end
      if (done || cyc == exp_done) chk(done && cyc == exp_done, "R9 done pulse", cyc, exp_done);
      if (ready_arm && req_ready) begin
        chk(cyc == ready_due, "R10 ready return", cyc, ready_due);
        ready_arm = 0;
      end
      if (req_ready && blen > 0) chk(0, "R10 ready during transfer", 1, 0);
      if (pend.exists(cyc)) begin sd_dq_in = pend[cyc]; pend.delete(cyc); end
      else sd_dq_in = 16'h0;
    end
  end

  initial forever begin
    bit took;
    @(negedge clk); took = wr_ready;
    @(posedge clk); #2;
    if (took && wr_src.size() > 0) void'(wr_src.pop_front());
    wr_data = (wr_src.size() > 0) ? wr_src[0] : 16'h0;
  end

  task automatic send_req(input bit w, input logic [11:0] r, input logic [7:0] c);
    req_write = w; req_row = r; req_col = c; req_valid = 1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1 req_valid = 0;
  endtask

  task automatic do_write(input logic [11:0] r, input logic [7:0] c, input int seed);
    for (int i = 0; i < 32; i++) begin
      logic [7:0] cc = c + 8'(i);
      logic [15:0] d = 16'(seed * 4099 + i * 263);
      wr_src.push_back(d);
      exp_wr_key.push_back(key_of(r, cc));
      exp_wr_dat.push_back(d);
      shadow[key_of(r, cc)] = d;
    end
    send_req(1, r, c);
  endtask

  task automatic do_read(input logic [11:0] r, input logic [7:0] c);
    for (int i = 0; i < 32; i++) begin
      logic [7:0] cc = c + 8'(i);
      exp_rd.push_back(shadow.exists(key_of(r, cc)) ? shadow[key_of(r, cc)] : pat(r, cc));
    end
    send_req(0, r, c);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog (R1..): run did not finish, actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk(sd_cs_n == 1'b1, "R1 reset select", sd_cs_n, 1);
      chk({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R3 reset commands", {sd_ras_n, sd_cas_n, sd_we_n}, 3'b111);
      chk(!sd_dq_oe, "R3 reset enable", sd_dq_oe, 0);
      chk(!req_ready, "R10 reset ready", req_ready, 0);
      chk(!done, "R9 reset done", done, 0);
      chk(!rd_valid, "R8 reset valid", rd_valid, 0);
    end
    #1 rst_n = 1;
    do @(negedge clk); while (!req_ready);
    chk({sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe} == 4'b1110, "R3 idle pins", {sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe}, 4'b1110);
    @(posedge clk); #1;
    do_write(12'h005, 8'h10, 1);
    do_read (12'h005, 8'h10);
    do_write(12'h005, 8'hF0, 2);
    do_read (12'h005, 8'hF0);
    do_read (12'h009, 8'h40);
    do_read (12'h005, 8'h10);
    do_write(12'hABC, 8'h00, 3);
    do_write(12'hABC, 8'h20, 4);
    do_read (12'hABC, 8'h00);
    do_read (12'hABC, 8'h20);
    do @(negedge clk); while (!(req_ready && exp_rd.size() == 0 && !ready_arm));
    repeat (4) @(negedge clk);
    chk(exp_wr_key.size() == 0, "R7 write words all used", exp_wr_key.size(), 0);
    chk(exp_rd.size() == 0, "R7 read words all returned", exp_rd.size(), 0);
    chk(rdcyc.size() == 0, "R8 read beats all answered", rdcyc.size(), 0);
    chk(rd_seen == 6 * 32, "R8 read word count", rd_seen, 6 * 32);
    finish_run();
  end
endmodule